// File: doc/BRIEF.md
# Asynchronous Parallel Memory Bus Master

This block turns single commands from a synchronous user port into timed accesses on an asynchronous SRAM/NOR-style parallel bus. The bus has separate address and 16-bit data pins, an active-low chip select, an active-low output enable and an active-low write enable. The block is meant to sit between on-chip logic and an external memory or a programmable-logic device. Such slow slaves sample the strobes without a shared clock, so each strobe has to stay active for a chosen number of cycles.

Every access runs through four stages: an address setup stage, a data stage, an address hold stage and a turnaround stage. The length of each stage is set in master clock cycles by a 4-bit count that software can change between accesses. Each count is read when its stage begins. On a write, the write strobe stays low for one cycle less than the data stage. On a read, the output enable falls together with chip select. The bus value is captured on the final data cycle and returned with a one-cycle acknowledge. Burst transfers, a ready pin and multiplexed address/data are not supported.

Top module: `pbus_master`

## Requirements
- R1: While reset is high and after it is released with no request, bus_cs_n, bus_oe_n and bus_we_n are 1, and bus_dq_oe, busy and ack are 0.
- R2: After a request is accepted at a clock edge, bus_cs_n is low for exactly S+D+H consecutive cycles, starting in the next cycle. S = max(cfg_setup,1), D = max(cfg_data,2) and H = cfg_hold. During those cycles bus_addr equals the accepted address and does not change.
- R3: On a read (req_write=0), bus_oe_n is low for exactly S+D cycles, from the first chip-select cycle to the end of the data stage, and bus_we_n stays 1.
- R4: On a write (req_write=1), bus_we_n is low for exactly D-1 cycles, from the first data-stage cycle onward. bus_oe_n stays 1, and bus_we_n is never low while bus_cs_n is high.
- R5: bus_dq_oe is 1 only during the S+D+H chip-select cycles of a write, with bus_dq_o holding the accepted write data. It is never 1 while bus_oe_n is low.
- R6: On a read, the value on bus_dq_i in the last data-stage cycle appears on rdata in the acknowledge cycle.
- R7: busy is 1 for exactly S+D+H+T cycles after acceptance, where T = cfg_turn. It is followed by exactly one cycle with ack=1, busy=0 and bus_cs_n=1.
- R8: A request is accepted only at an edge where req_valid=1 and busy=0, and this includes the acknowledge cycle, so back-to-back accesses are possible. Requests raised while busy=1 have no effect on the bus or on the results.
- R9: A setup count of 0 acts as 1, and a data count below 2 acts as 2. A hold or turnaround count of 0 skips that stage. Counts up to 15 are accepted.
- R10: During the T turnaround cycles, chip select and all strobes are inactive, and the bus is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Command request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | 16 | Write data |
| cfg_setup | input | 4 | Address setup stage length |
| cfg_data | input | 4 | Data stage length |
| cfg_hold | input | 4 | Address hold stage length |
| cfg_turn | input | 4 | Turnaround length |
| busy | output | 1 | Access in progress |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Captured read data |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_oe_n | output | 1 | Output enable, active low |
| bus_we_n | output | 1 | Write enable, active low |
| bus_addr | output | ADDR_W | Bus address |
| bus_dq_o | output | 16 | Data driven to the bus |
| bus_dq_oe | output | 1 | Data bus drive enable |
| bus_dq_i | input | 16 | Data read from the bus |

## Verification
The acknowledge of one access and the acceptance of the next can fall in the same cycle, because busy drops in the acknowledge cycle. The driver sets up that overlap on purpose: it holds the next request pending while the current access is still running, so acceptance happens at the very edge that ends the acknowledge cycle. The scoreboard then confirms two things for both accesses. The earlier access still returns its own read data. The new access starts with full-length strobe counts and the correct address, with no extra or lost cycles between them.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

    localparam int DATA_W = 16;
    localparam int CNT_W  = 4;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_SETUP = 3'd1,
        PH_DATA  = 3'd2,
        PH_HOLD  = 3'd3,
        PH_TURN  = 3'd4,
        PH_DONE  = 3'd5
    } phase_e;

    // Setup stage never shorter than one cycle.
    function automatic logic [CNT_W-1:0] eff_setup(input logic [CNT_W-1:0] v);
        return (v == '0) ? CNT_W'(1) : v;
    endfunction

    // Data stage at least two cycles so the write strobe is never empty.
    function automatic logic [CNT_W-1:0] eff_data(input logic [CNT_W-1:0] v);
        return (v < CNT_W'(2)) ? CNT_W'(2) : v;
    endfunction

endpackage

// File: rtl/pbus_phase_seq.sv
module pbus_phase_seq
    import pbus_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] cfg_setup,
    input  logic [CNT_W-1:0] cfg_data,
    input  logic [CNT_W-1:0] cfg_hold,
    input  logic [CNT_W-1:0] cfg_turn,
    output phase_e           ph_q,
    output phase_e           ph_d,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_d
);

    logic             last;
    phase_e           after_hold_ph, after_data_ph;
    logic [CNT_W-1:0] after_hold_cnt, after_data_cnt;

    assign last = (cnt_q == '0);

    always_comb begin
        if (cfg_turn != '0) begin
            after_hold_ph  = PH_TURN;
            after_hold_cnt = cfg_turn - CNT_W'(1);
        end else begin
            after_hold_ph  = PH_DONE;
            after_hold_cnt = '0;
        end
        if (cfg_hold != '0) begin
            after_data_ph  = PH_HOLD;
            after_data_cnt = cfg_hold - CNT_W'(1);
        end else begin
            after_data_ph  = after_hold_ph;
            after_data_cnt = after_hold_cnt;
        end
    end

    always_comb begin
        ph_d  = ph_q;
        cnt_d = last ? cnt_q : cnt_q - CNT_W'(1);
        case (ph_q)
            PH_IDLE, PH_DONE: begin
                if (start) begin
                    ph_d  = PH_SETUP;
                    cnt_d = eff_setup(cfg_setup) - CNT_W'(1);
                end else begin
                    ph_d  = PH_IDLE;
                    cnt_d = '0;
                end
            end
            PH_SETUP: if (last) begin
                ph_d  = PH_DATA;
                cnt_d = eff_data(cfg_data) - CNT_W'(1);
            end
            PH_DATA: if (last) begin
                ph_d  = after_data_ph;
                cnt_d = after_data_cnt;
            end
            PH_HOLD: if (last) begin
                ph_d  = after_hold_ph;
                cnt_d = after_hold_cnt;
            end
            PH_TURN: if (last) begin
                ph_d  = PH_DONE;
                cnt_d = '0;
            end
            default: begin
                ph_d  = PH_IDLE;
                cnt_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= PH_IDLE;
            cnt_q <= '0;
        end else begin
            ph_q  <= ph_d;
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/pbus_pin_drv.sv
module pbus_pin_drv
    import pbus_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  phase_e            ph_d,
    input  logic [CNT_W-1:0]  cnt_d,
    input  logic              wr_d,
    input  logic              load,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              cs_n,
    output logic              oe_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] dq_o,
    output logic              dq_oe
);

    logic in_access, in_read_win, in_write_strobe;

    // Pins are registered from the next-stage values, so they are glitch-free
    // and stay aligned with the stage register.
    assign in_access       = (ph_d == PH_SETUP) || (ph_d == PH_DATA) || (ph_d == PH_HOLD);
    assign in_read_win     = !wr_d && ((ph_d == PH_SETUP) || (ph_d == PH_DATA));
    assign in_write_strobe = wr_d && (ph_d == PH_DATA) && (cnt_d != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_n  <= 1'b1;
            oe_n  <= 1'b1;
            we_n  <= 1'b1;
            dq_oe <= 1'b0;
            addr  <= '0;
            dq_o  <= '0;
        end else begin
            cs_n  <= !in_access;
            oe_n  <= !in_read_win;
            we_n  <= !in_write_strobe;
            dq_oe <= wr_d && in_access;
            if (load) begin
                addr <= req_addr;
                dq_o <= req_wdata;
            end
        end
    end

endmodule

// File: rtl/pbus_rd_capture.sv
module pbus_rd_capture
    import pbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              grab,
    input  logic [DATA_W-1:0] dq_i,
    output logic [DATA_W-1:0] rdata
);

    always_ff @(posedge clk) begin
        if (rst)       rdata <= '0;
        else if (grab) rdata <= dq_i;
    end

endmodule

// File: rtl/pbus_master.sv
module pbus_master
    import pbus_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [15:0]       req_wdata,
    input  logic [3:0]        cfg_setup,
    input  logic [3:0]        cfg_data,
    input  logic [3:0]        cfg_hold,
    input  logic [3:0]        cfg_turn,
    output logic              busy,
    output logic              ack,
    output logic [15:0]       rdata,
    output logic              bus_cs_n,
    output logic              bus_oe_n,
    output logic              bus_we_n,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [15:0]       bus_dq_o,
    output logic              bus_dq_oe,
    input  logic [15:0]       bus_dq_i
);

    phase_e           ph_q, ph_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             start, wr_q, wr_d, grab;

    assign busy  = (ph_q != PH_IDLE) && (ph_q != PH_DONE);
    assign ack   = (ph_q == PH_DONE);
    assign start = req_valid && !busy;
    assign wr_d  = start ? req_write : wr_q;
    assign grab  = (ph_q == PH_DATA) && (cnt_q == '0) && !wr_q;

    always_ff @(posedge clk) begin
        if (rst)        wr_q <= 1'b0;
        else if (start) wr_q <= req_write;
    end

    pbus_phase_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .cfg_setup (cfg_setup),
        .cfg_data  (cfg_data),
        .cfg_hold  (cfg_hold),
        .cfg_turn  (cfg_turn),
        .ph_q      (ph_q),
        .ph_d      (ph_d),
        .cnt_q     (cnt_q),
        .cnt_d     (cnt_d)
    );

    pbus_pin_drv #(.ADDR_W(ADDR_W)) u_pins (
        .clk       (clk),
        .rst       (rst),
        .ph_d      (ph_d),
        .cnt_d     (cnt_d),
        .wr_d      (wr_d),
        .load      (start),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .cs_n      (bus_cs_n),
        .oe_n      (bus_oe_n),
        .we_n      (bus_we_n),
        .addr      (bus_addr),
        .dq_o      (bus_dq_o),
        .dq_oe     (bus_dq_oe)
    );

    pbus_rd_capture u_cap (
        .clk   (clk),
        .rst   (rst),
        .grab  (grab),
        .dq_i  (bus_dq_i),
        .rdata (rdata)
    );

endmodule

// File: rtl/pbus_master_chk.sv
module pbus_master_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              busy,
    input logic              ack,
    input logic              bus_cs_n,
    input logic              bus_oe_n,
    input logic              bus_we_n,
    input logic              bus_dq_oe,
    input logic [ADDR_W-1:0] bus_addr
);

    // R4
    we_in_cs_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_we_n |-> (!bus_cs_n && bus_oe_n));

    // R5
    no_contention_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_oe_n |-> !bus_dq_oe);

    // R7
    ack_single_chk: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);

    // R7
    ack_released_chk: assert property (@(posedge clk) disable iff (rst)
        ack |-> (!busy && bus_cs_n));

    // R8
    accept_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy) |=> busy);

    // R2
    addr_steady_chk: assert property (@(posedge clk) disable iff (rst)
        (!bus_cs_n && !$past(bus_cs_n)) |-> $stable(bus_addr));

    // R10
    idle_dq_chk: assert property (@(posedge clk) disable iff (rst)
        bus_cs_n |-> (!bus_dq_oe && bus_we_n && bus_oe_n));

endmodule

bind pbus_master pbus_master_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .busy      (busy),
    .ack       (ack),
    .bus_cs_n  (bus_cs_n),
    .bus_oe_n  (bus_oe_n),
    .bus_we_n  (bus_we_n),
    .bus_dq_oe (bus_dq_oe),
    .bus_addr  (bus_addr)
);

// File: tb/pbus_master_test.sv
module pbus_master_test;

    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [15:0]   req_wdata = '0;
    logic [3:0]    cfg_setup = 4'd5, cfg_data = 4'd4, cfg_hold = 4'd1, cfg_turn = 4'd0;
    logic          busy, ack, bus_cs_n, bus_oe_n, bus_we_n, bus_dq_oe;
    logic [15:0]   rdata, bus_dq_o, bus_dq_i;
    logic [AW-1:0] bus_addr;

    always #2.5 clk = ~clk;

    pbus_master #(.ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .cfg_setup(cfg_setup),
        .cfg_data(cfg_data), .cfg_hold(cfg_hold), .cfg_turn(cfg_turn),
        .busy(busy), .ack(ack), .rdata(rdata), .bus_cs_n(bus_cs_n),
        .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n), .bus_addr(bus_addr),
        .bus_dq_o(bus_dq_o), .bus_dq_oe(bus_dq_oe), .bus_dq_i(bus_dq_i)
    );

    // Slave memory model: drives while output enable is low, stores on the write strobe's rising edge.
    logic [15:0] slave_mem [16];
    logic [15:0] model_mem [16];
    logic        we_prev;

    assign bus_dq_i = !bus_oe_n ? slave_mem[bus_addr[3:0]] : 16'hDEAD;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 16; i++) slave_mem[i] <= 16'(i * 16'h1111);
            we_prev <= 1'b1;
        end else begin
            if (!we_prev && bus_we_n) slave_mem[bus_addr[3:0]] <= bus_dq_o;
            we_prev <= bus_we_n;
        end
    end

    typedef struct {
        bit          wr;
        logic [AW-1:0] addr;
        logic [15:0] data;
        int          n_busy, n_cs, n_we, n_oe, n_dqoe;
    } exp_t;

    exp_t q[$];
    int   vecs = 0, errs = 0;
    int   c_busy = 0, c_cs = 0, c_we = 0, c_oe = 0, c_dqoe = 0, c_addr_bad = 0, c_dq_bad = 0;

    task automatic chk(bit ok, string tag, int act, int exp);
        vecs++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (busy) c_busy++;
            if (!bus_we_n) c_we++;
            if (!bus_oe_n) c_oe++;
            if (bus_dq_oe) c_dqoe++;
            if (!bus_cs_n) begin
                c_cs++;
                if (q.size() > 0 && bus_addr != q[0].addr) c_addr_bad++;
                if (q.size() > 0 && bus_dq_oe && bus_dq_o != q[0].data) c_dq_bad++;
            end
            if (ack) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R8 acknowledge with no accepted request", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(c_busy == e.n_busy, "R7 R10 busy length", c_busy, e.n_busy);
                    chk(c_cs == e.n_cs, "R2 R9 chip select length", c_cs, e.n_cs);
                    chk(c_addr_bad == 0, "R2 address stable", c_addr_bad, 0);
                    chk(c_we == e.n_we, "R4 write strobe length", c_we, e.n_we);
                    chk(c_oe == e.n_oe, "R3 output enable length", c_oe, e.n_oe);
                    chk(c_dqoe == e.n_dqoe, "R5 drive enable length", c_dqoe, e.n_dqoe);
                    chk(c_dq_bad == 0, "R5 driven data", c_dq_bad, 0);
                    if (!e.wr) chk(rdata == e.data, "R6 read data", rdata, e.data);
                end
                c_busy = 0; c_cs = 0; c_we = 0; c_oe = 0; c_dqoe = 0;
                c_addr_bad = 0; c_dq_bad = 0;
            end
        end
    end

    // Driver: computes expectations from the configuration and queues them.
    task automatic issue(bit wr, logic [AW-1:0] a, logic [15:0] d);
        exp_t e;
        int   s, dd, h, t;
        s  = (cfg_setup == 0) ? 1 : int'(cfg_setup);
        dd = (cfg_data < 2) ? 2 : int'(cfg_data);
        h  = int'(cfg_hold);
        t  = int'(cfg_turn);
        e.wr     = wr;
        e.addr   = a;
        e.data   = wr ? d : model_mem[a[3:0]];
        e.n_busy = s + dd + h + t;
        e.n_cs   = s + dd + h;
        e.n_we   = wr ? dd - 1 : 0;
        e.n_oe   = wr ? 0 : s + dd;
        e.n_dqoe = wr ? s + dd + h : 0;
        if (wr) model_mem[a[3:0]] = d;
        @(negedge clk);
        req_write = wr; req_addr = a; req_wdata = d; req_valid = 1'b1;
        while (busy) @(negedge clk);
        q.push_back(e);
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    task automatic drain();
        while (q.size() != 0 || busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic set_cfg(logic [3:0] s, logic [3:0] d, logic [3:0] h, logic [3:0] t);
        drain();
        cfg_setup = s; cfg_data = d; cfg_hold = h; cfg_turn = t;
    endtask

    initial begin
        for (int i = 0; i < 16; i++) model_mem[i] = 16'(i * 16'h1111);
        repeat (3) @(negedge clk);
        // R1 during reset
        chk({bus_cs_n, bus_oe_n, bus_we_n} == 3'b111, "R1 strobes in reset", {bus_cs_n, bus_oe_n, bus_we_n}, 7);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        // R1 after reset, idle
        chk({bus_cs_n, bus_oe_n, bus_we_n} == 3'b111, "R1 strobes idle", {bus_cs_n, bus_oe_n, bus_we_n}, 7);
        chk({bus_dq_oe, busy, ack} == 3'b000, "R1 flags idle", {bus_dq_oe, busy, ack}, 0);

        // Default timing, back-to-back so acknowledge and acceptance share a cycle (R8)
        set_cfg(4'd5, 4'd4, 4'd1, 4'd0);
        issue(1'b1, 16'h0001, 16'hA5A5);
        issue(1'b1, 16'h0002, 16'h5A5A);
        issue(1'b0, 16'h0001, 16'h0);
        issue(1'b0, 16'h0002, 16'h0);

        // Longest required setup/data
        set_cfg(4'd9, 4'd8, 4'd1, 4'd0);
        issue(1'b1, 16'h0003, 16'h1234);
        issue(1'b0, 16'h0003, 16'h0);
        issue(1'b0, 16'h0000, 16'h0);

        // Shortest legal timing, no hold
        set_cfg(4'd1, 4'd2, 4'd0, 4'd0);
        issue(1'b1, 16'h0004, 16'hBEEF);
        issue(1'b0, 16'h0004, 16'h0);

        // R9 zero counts clamp; R10 turnaround cycles
        set_cfg(4'd0, 4'd0, 4'd0, 4'd3);
        issue(1'b1, 16'h0005, 16'hC0DE);
        issue(1'b0, 16'h0005, 16'h0);

        set_cfg(4'd2, 4'd3, 4'd3, 4'd2);
        issue(1'b1, 16'h0006, 16'h0F0F);
        issue(1'b0, 16'h0006, 16'h0);

        // R9 maximum counts
        set_cfg(4'd15, 4'd15, 4'd15, 4'd15);
        issue(1'b1, 16'h0007, 16'h7777);
        issue(1'b0, 16'h0007, 16'h0);

        // R8 requests raised while busy are ignored
        set_cfg(4'd5, 4'd4, 4'd1, 4'd0);
        issue(1'b1, 16'h0008, 16'h8888);
        @(negedge clk);
        req_write = 1'b1; req_addr = 16'h0009; req_wdata = 16'hFFFF; req_valid = 1'b1;
        @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        drain();
        issue(1'b0, 16'h0009, 16'h0);
        issue(1'b0, 16'h0008, 16'h0);
        drain();
        chk(q.size() == 0, "R8 queue empty at end", q.size(), 0);

        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        #500000;
        vecs++;
        errs++;
        $display("FAIL R7 watchdog expired actual=%0h expected=%0h", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

endmodule